// File: doc/BRIEF.md
# Paired-Register Doubleword Load/Store Address Unit

This block is the address and data-steering stage for 64-bit memory transfers that use two 32-bit registers, an even one and an odd one. For each accepted instruction it takes:

- a 5-bit addressing-mode field;
- a base value and a register offset;
- an 8-bit immediate split into two 4-bit halves;
- the two source register values.

From these it forms the memory address and the updated base value. It also packs the store word, or splits a returned load word into its two 32-bit results.

The memory side uses a one-cycle request pulse and a response strobe. The memory returns a response for stores as well as for loads. One cycle after the response, a `done` pulse is raised. The load results and the base writeback enable and value are presented together with `done`, so the register file applies them exactly once per instruction.

Top module: `dwls_unit`

## Requirements
- R1: Bits of `mode` from bit 4 down to bit 0 are: pre-index, add, immediate offset, writeback, load.
- R2: With pre-index=0, `mem_addr` equals the base. The base is always written back with base plus or minus the offset.
- R3: With pre-index=1, `mem_addr` is base plus or minus the offset. The same value is written back to the base only when writeback=1. With writeback=0, `base_we` stays low.
- R4: With add=1 the offset is added to the base; with add=0 it is subtracted. This holds for both the register and the immediate offset. Arithmetic wraps modulo 2^32.
- R5: The immediate offset is {`imm_hi`, `imm_lo`}, zero-extended to 32 bits.
- R6: `mem_we` is the inverse of the load bit. The store word `mem_wdata` holds `src_even` in bits 31:0 and `src_odd` in bits 63:32.
- R7: On a load, `ld_even` takes `mem_rdata[31:0]` and `ld_odd` takes `mem_rdata[63:32]`. A store leaves both load outputs unchanged.
- R8: `mem_req` is a single-cycle pulse in the cycle after `start` is accepted while idle. A `start` while busy is ignored.
- R9: A response is taken in the request cycle or any later cycle. `done` is a single-cycle pulse in the cycle after the response. `busy` is low in the cycle after `done`.
- R10: `base_we` is high only in the `done` cycle.
- R11: After reset, `busy`, `mem_req`, `done`, `base_we`, `ld_even` and `ld_odd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction valid; accepted when not busy |
| mode | input | 5 | Addressing mode {pre, add, imm, wb, load} |
| base_in | input | 32 | Base register value |
| offset_in | input | 32 | Register offset value |
| imm_hi | input | 4 | Upper half of the immediate offset |
| imm_lo | input | 4 | Lower half of the immediate offset |
| src_even | input | 32 | Even register of the pair (store) |
| src_odd | input | 32 | Odd register of the pair (store) |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 64 | Store word |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rdata | input | 64 | Load word from memory |
| done | output | 1 | Instruction complete pulse |
| base_we | output | 1 | Base writeback enable (with done) |
| base_wdata | output | 32 | New base value |
| ld_even | output | 32 | Load result for the even register |
| ld_odd | output | 32 | Load result for the odd register |

## Verification
The stimulus table covers the mode matrix with a fixed base and register offset:

- pre- against post-index, shown by whether `mem_addr` moves from the base;
- add against subtract, shown by which side of the base the result falls;
- register against immediate offset, shown by a step of 0x10 against 0x25;
- writeback set and clear under pre-index, shown by `base_we`.

Response latencies of zero to three cycles separate a response in the request cycle from later ones. Each entry uses distinct source and return words, so a swapped even/odd half shows up. Directed cases cover:

- an address below zero that wraps;
- the all-ones immediate, which exposes sign extension;
- a `start` raised while busy.

// File: rtl/dwls_pkg.sv
package dwls_pkg;

    typedef struct packed {
        logic pre;
        logic add;
        logic imm;
        logic wb;
        logic load;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } state_t;

    function automatic mode_t unpack_mode(input logic [4:0] raw);
        return mode_t'(raw);
    endfunction

endpackage

// File: rtl/dwls_addr_gen.sv
module dwls_addr_gen #(
    parameter int DW   = 32,
    parameter int IMMW = 4
) (
    input  logic          pre,
    input  logic          add,
    input  logic          imm,
    input  logic          wb,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] roff,
    input  logic [IMMW-1:0] imm_hi,
    input  logic [IMMW-1:0] imm_lo,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] base_next,
    output logic          base_we
);
    localparam int IMM_TOT = 2 * IMMW;
    localparam int PAD_W   = DW - IMM_TOT;

    logic [DW-1:0] offset;
    logic [DW-1:0] moved;

    always_comb begin
        offset    = imm ? {{PAD_W{1'b0}}, imm_hi, imm_lo} : roff;
        moved     = add ? (base + offset) : (base - offset);
        addr      = pre ? moved : base;
        base_next = moved;
        base_we   = !pre || wb;
    end
endmodule

// File: rtl/dwls_data_steer.sv
module dwls_data_steer #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   src_even,
    input  logic [DW-1:0]   src_odd,
    input  logic [2*DW-1:0] rdata,
    output logic [2*DW-1:0] wdata,
    output logic [DW-1:0]   rd_even,
    output logic [DW-1:0]   rd_odd
);
    always_comb begin
        wdata   = {src_odd, src_even};
        rd_even = rdata[DW-1:0];
        rd_odd  = rdata[2*DW-1:DW];
    end
endmodule

// File: rtl/dwls_seq.sv
module dwls_seq
    import dwls_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   rsp_valid,
    output state_t state,
    output logic   accept,
    output logic   take
);
    state_t nxt;

    always_comb begin
        accept = (state == ST_IDLE) && start;
        take   = ((state == ST_REQ) || (state == ST_WAIT)) && rsp_valid;
        nxt    = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_REQ;
            ST_REQ:  nxt = rsp_valid ? ST_DONE : ST_WAIT;
            ST_WAIT: if (rsp_valid) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/dwls_unit.sv
module dwls_unit
    import dwls_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IMMW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        mode,
    input  logic [DW-1:0]     base_in,
    input  logic [DW-1:0]     offset_in,
    input  logic [IMMW-1:0]   imm_hi,
    input  logic [IMMW-1:0]   imm_lo,
    input  logic [DW-1:0]     src_even,
    input  logic [DW-1:0]     src_odd,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [2*DW-1:0]   mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [2*DW-1:0]   mem_rdata,
    output logic              done,
    output logic              base_we,
    output logic [DW-1:0]     base_wdata,
    output logic [DW-1:0]     ld_even,
    output logic [DW-1:0]     ld_odd
);
    localparam int QW = 2 * DW;

    mode_t          m;
    state_t         st;
    logic           accept, take;
    logic [DW-1:0]  ag_addr, ag_bnext;
    logic           ag_bwe;
    logic [QW-1:0]  ds_wdata;
    logic [DW-1:0]  ds_even, ds_odd;

    logic [DW-1:0]  addr_q, bnext_q, even_q, odd_q;
    logic [QW-1:0]  wdata_q;
    logic           we_q, bwe_q;

    assign m = unpack_mode(mode);

    dwls_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rsp_valid (mem_rsp_valid),
        .state     (st),
        .accept    (accept),
        .take      (take)
    );

    dwls_addr_gen #(.DW(DW), .IMMW(IMMW)) u_agen (
        .pre       (m.pre),
        .add       (m.add),
        .imm       (m.imm),
        .wb        (m.wb),
        .base      (base_in),
        .roff      (offset_in),
        .imm_hi    (imm_hi),
        .imm_lo    (imm_lo),
        .addr      (ag_addr),
        .base_next (ag_bnext),
        .base_we   (ag_bwe)
    );

    dwls_data_steer #(.DW(DW)) u_steer (
        .src_even (src_even),
        .src_odd  (src_odd),
        .rdata    (mem_rdata),
        .wdata    (ds_wdata),
        .rd_even  (ds_even),
        .rd_odd   (ds_odd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            bnext_q <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            bwe_q   <= 1'b0;
            even_q  <= '0;
            odd_q   <= '0;
        end else begin
            if (accept) begin
                addr_q  <= ag_addr;
                bnext_q <= ag_bnext;
                bwe_q   <= ag_bwe;
                we_q    <= !m.load;
                wdata_q <= ds_wdata;
            end
            if (take && !we_q) begin
                even_q <= ds_even;
                odd_q  <= ds_odd;
            end
        end
    end

    assign busy       = (st != ST_IDLE);
    assign mem_req    = (st == ST_REQ);
    assign done       = (st == ST_DONE);
    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign base_we    = done && bwe_q;
    assign base_wdata = bnext_q;
    assign ld_even    = even_q;
    assign ld_odd     = odd_q;
endmodule

// File: rtl/dwls_unit_chk.sv
module dwls_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_rsp_valid,
    input logic          done,
    input logic          base_we,
    input logic [DW-1:0] ld_even,
    input logic [DW-1:0] ld_odd
);
    assert_req_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> mem_req);

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && busy && !done) |=> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_bwe_only_done_R10: assert property (@(posedge clk) disable iff (rst)
        base_we |-> done);

    assert_store_keeps_ld_R7: assert property (@(posedge clk) disable iff (rst)
        (done && mem_we) |-> ($stable(ld_even) && $stable(ld_odd)));
endmodule

bind dwls_unit dwls_unit_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .base_we       (base_we),
    .ld_even       (ld_even),
    .ld_odd        (ld_odd)
);

// File: tb/test_dwls_unit.sv
module test_dwls_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  mode = '0;
    logic [31:0] base_in = '0, offset_in = '0, src_even = '0, src_odd = '0;
    logic [3:0]  imm_hi = '0, imm_lo = '0;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        busy, mem_req, mem_we, done, base_we;
    logic [31:0] mem_addr, base_wdata, ld_even, ld_odd;
    logic [63:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] prev_even = '0, prev_odd = '0;

    always #2 clk = ~clk;

    dwls_unit i_dwls_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .base_in(base_in), .offset_in(offset_in),
        .imm_hi(imm_hi), .imm_lo(imm_lo),
        .src_even(src_even), .src_odd(src_odd),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .done(done), .base_we(base_we), .base_wdata(base_wdata),
        .ld_even(ld_even), .ld_odd(ld_odd)
    );

    // mode bits {pre, add, imm, wb, load} (R1); base 0x1000, reg offset 0x10, imm 0x25
    typedef struct packed {
        logic [4:0]  mode;
        logic [3:0]  lat;
        logic [31:0] addr;
        logic        bwe;
        logic [31:0] bnew;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{5'b00000, 4'd0, 32'h0000_1000, 1'b1, 32'h0000_0FF0}, // R2 post sub reg store
        '{5'b01001, 4'd1, 32'h0000_1000, 1'b1, 32'h0000_1010}, // R2 post add reg load
        '{5'b00101, 4'd2, 32'h0000_1000, 1'b1, 32'h0000_0FDB}, // R4 post sub imm load
        '{5'b10000, 4'd3, 32'h0000_0FF0, 1'b0, 32'h0000_0000}, // R3 pre sub reg, no wb
        '{5'b10011, 4'd0, 32'h0000_0FF0, 1'b1, 32'h0000_0FF0}, // R3 pre sub reg wb load
        '{5'b11101, 4'd1, 32'h0000_1025, 1'b0, 32'h0000_0000}, // R5 pre add imm load
        '{5'b11110, 4'd2, 32'h0000_1025, 1'b1, 32'h0000_1025}, // R5 pre add imm wb store
        '{5'b10110, 4'd0, 32'h0000_0FDB, 1'b1, 32'h0000_0FDB}, // R4 pre sub imm wb
        '{5'b01100, 4'd3, 32'h0000_1000, 1'b1, 32'h0000_1025}  // R2 post add imm store
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] md, input logic [31:0] b, input logic [31:0] ro,
                          input logic [3:0] hi, input logic [3:0] lo, input int lat,
                          input logic [31:0] ev, input logic [31:0] od, input logic [63:0] rd,
                          input logic [31:0] exp_addr, input logic exp_bwe, input logic [31:0] exp_bnew);
        @(negedge clk);
        start = 1'b1; mode = md; base_in = b; offset_in = ro;
        imm_hi = hi; imm_lo = lo; src_even = ev; src_odd = od;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req === 1'b1, "R8 req", {63'd0, mem_req}, 64'd1);
        chk(mem_addr === exp_addr, "R2/R3 addr", {32'd0, mem_addr}, {32'd0, exp_addr});
        chk(mem_we === !md[0], "R6 we", {63'd0, mem_we}, {63'd0, !md[0]});
        if (!md[0]) chk(mem_wdata === {od, ev}, "R6 wdata", mem_wdata, {od, ev});
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk(!mem_req && !done, "R9 wait", {62'd0, mem_req, done}, 64'd0);
        end
        mem_rsp_valid = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(done === 1'b1, "R9 done", {63'd0, done}, 64'd1);
        chk(base_we === exp_bwe, "R3/R10 base_we", {63'd0, base_we}, {63'd0, exp_bwe});
        if (exp_bwe) chk(base_wdata === exp_bnew, "R2/R4 base_wdata", {32'd0, base_wdata}, {32'd0, exp_bnew});
        if (md[0]) begin
            chk(ld_even === rd[31:0] && ld_odd === rd[63:32], "R7 load split",
                {ld_odd, ld_even}, rd);
            prev_even = rd[31:0]; prev_odd = rd[63:32];
        end else begin
            chk(ld_even === prev_even && ld_odd === prev_odd, "R7 store keeps",
                {ld_odd, ld_even}, {prev_odd, prev_even});
        end
        @(negedge clk);
        chk(!done && !busy && !base_we, "R9/R10 after done", {61'd0, done, busy, base_we}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(!busy && !mem_req && !done && !base_we, "R11 ctrl", {60'd0, busy, mem_req, done, base_we}, 64'd0);
        chk(ld_even === 32'd0 && ld_odd === 32'd0, "R11 ld", {ld_odd, ld_even}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].mode, 32'h0000_1000, 32'h0000_0010, 4'h2, 4'h5, int'(VEC[i].lat),
                   32'h1111_0000 + i, 32'h2222_0000 + i,
                   {32'hA5A5_0000 + i, 32'h5A5A_0000 + i},
                   VEC[i].addr, VEC[i].bwe, VEC[i].bnew);
        end

        // R4 wrap below zero: pre sub reg wb load, 0x8 - 0x10
        run_op(5'b10011, 32'h8, 32'h10, 4'h0, 4'h0, 1, 32'h0, 32'h0,
               64'hDEAD_BEEF_0123_4567, 32'hFFFF_FFF8, 1'b1, 32'hFFFF_FFF8);
        // R5 all-ones immediate is zero-extended: pre add imm wb store
        run_op(5'b11110, 32'h0, 32'hFFFF_FFFF, 4'hF, 4'hF, 0, 32'hCAFE_0001, 32'hCAFE_0002,
               64'h0, 32'h0000_00FF, 1'b1, 32'h0000_00FF);

        // R8 start while busy is ignored
        @(negedge clk);
        start = 1'b1; mode = 5'b00001; base_in = 32'h4000; offset_in = 32'h4;
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === 32'h4000, "R8 first req", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, 32'h4000});
        mode = 5'b11010; base_in = 32'h9000;   // start still high while busy
        @(negedge clk);
        start = 1'b0;
        chk(mem_req === 1'b0 && mem_addr === 32'h4000, "R8 busy start ignored", {31'd0, mem_req, mem_addr}, {31'd0, 1'b0, 32'h4000});
        mem_rsp_valid = 1'b1; mem_rdata = 64'h7777_8888_9999_AAAA;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(done && base_we && base_wdata === 32'h3FFC, "R8 first op base", {32'd0, base_wdata}, 64'h3FFC);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!mem_req && !busy, "R8 no second req", {62'd0, mem_req, busy}, 64'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule